// File: doc/BRIEF.md
# Return-From-Trap Control Unit

This unit resolves the outcome of a return-from-trap instruction. When the instruction executes, the pipeline pulses `valid_i` for one cycle and presents the current PC, the live status bits (supervisor, previous supervisor, trap enable), the debug-mode flag, the debug-select bit taken from the instruction word, the two saved return addresses and the saved debug status bits. One cycle later the unit presents a registered result: the PC to fetch next, the new supervisor and trap-enable bits, and one-cycle pulses that request a halt, an illegal-instruction fault, or the clearing of debug mode.

The conditions are tested in a fixed priority. A return issued outside supervisor mode only steps the PC, because another unit reports the privilege fault; if traps are also disabled, a halt is requested. A return in supervisor mode with traps still enabled is illegal. Otherwise a normal return (not in debug mode, select bit 0) or a debug return (in debug mode, select bit 1) restores state. Every other combination only steps the PC.

Top module: `rett_ctl`

## Requirements
- R1: While `rst_ni` is low and until the first accepted return, `next_pc_o` is 0, `sup_o` is 1, `trap_en_o` is 0 and `halt_o`, `illegal_o`, `dbg_clr_o`, `done_o` are 0.
- R2: With supervisor 0 and trap enable 0, the result is next PC = PC + 4, `halt_o` pulsed, status outputs equal to the presented status.
- R3: With supervisor 0 and trap enable 1, the result is next PC = PC + 4, status unchanged, and no request pulse.
- R4: With supervisor 1 and trap enable 1, the result is next PC = PC + 4, `illegal_o` pulsed, status unchanged.
- R5: With supervisor 1, trap enable 0, debug mode 0 and select bit 0, next PC is `trap_pc_i`, `trap_en_o` becomes 1 and `sup_o` takes `prev_sup_i`.
- R6: With supervisor 1, trap enable 0, debug mode 1 and select bit 1, next PC is `dbg_pc_i`, `trap_en_o` takes `dbg_trap_en_i`, `sup_o` takes `dbg_sup_i`, and `dbg_clr_o` is pulsed.
- R7: With supervisor 1 and trap enable 0, a mismatch between debug mode and the select bit gives next PC = PC + 4 with status unchanged and no pulse.
- R8: Priority is supervisor-clear first, then trap-enable-set, then normal return, then debug return; debug mode and the select bit have no effect on the first two outcomes.
- R9: Outputs change only on the clock edge that samples `valid_i` high, one cycle after it; `done_o` and every request pulse last exactly one cycle and the PC and status outputs hold in between.
- R10: The PC + 4 step wraps modulo 2^PC_W.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Return-from-trap executes this cycle |
| pc_i | input | PC_W | PC of the return instruction |
| sup_i | input | 1 | Current supervisor bit |
| prev_sup_i | input | 1 | Previous supervisor bit |
| trap_en_i | input | 1 | Current trap-enable bit |
| dbg_mode_i | input | 1 | Processor is in debug mode |
| dbg_field_i | input | 1 | Debug-select bit of the instruction |
| trap_pc_i | input | PC_W | Saved return address for normal traps |
| dbg_pc_i | input | PC_W | Saved return address for debug entry |
| dbg_sup_i | input | 1 | Supervisor bit saved on debug entry |
| dbg_trap_en_i | input | 1 | Trap-enable bit saved on debug entry |
| next_pc_o | output | PC_W | Next fetch address |
| sup_o | output | 1 | Updated supervisor bit |
| trap_en_o | output | 1 | Updated trap-enable bit |
| dbg_clr_o | output | 1 | One-cycle request to leave debug mode |
| halt_o | output | 1 | One-cycle halt request |
| illegal_o | output | 1 | One-cycle illegal-instruction request |
| done_o | output | 1 | One-cycle marker that results are new |

## Verification
Twelve status combinations cover every outcome at least twice, with differing saved status values so a restored bit cannot be confused with a held one. Pairs that differ only in debug mode or the select bit show whether those inputs leak into the halt, user and illegal outcomes, and the two mismatched debug cases separate a true no-op from a wrongly taken return. Directed cases look at the reset values, the idle cycle after a result, back-to-back returns and the PC wrap at the top of the address space.

// File: rtl/rett_pkg.sv
package rett_pkg;
  typedef enum logic [2:0] {
    RT_HALT    = 3'd0,
    RT_USER    = 3'd1,
    RT_ILLEGAL = 3'd2,
    RT_NORMAL  = 3'd3,
    RT_DEBUG   = 3'd4,
    RT_NOP     = 3'd5
  } rt_kind_e;
endpackage

// File: rtl/rett_classify.sv
module rett_classify
  import rett_pkg::*;
(
  input  logic     sup_i,
  input  logic     trap_en_i,
  input  logic     dbg_mode_i,
  input  logic     dbg_field_i,
  output rt_kind_e kind_o
);
  // fixed priority: user, enabled traps, normal, debug
  always_comb begin
    if (!sup_i)
      kind_o = trap_en_i ? RT_USER : RT_HALT;
    else if (trap_en_i)
      kind_o = RT_ILLEGAL;
    else if (!dbg_mode_i && !dbg_field_i)
      kind_o = RT_NORMAL;
    else if (dbg_mode_i && dbg_field_i)
      kind_o = RT_DEBUG;
    else
      kind_o = RT_NOP;
  end

  // R8
  always_comb begin
    user_prio_chk: assert (sup_i || kind_o == RT_HALT || kind_o == RT_USER);
  end
endmodule

// File: rtl/rett_target.sv
module rett_target
  import rett_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int STEP = 4
) (
  input  rt_kind_e        kind_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] trap_pc_i,
  input  logic [PC_W-1:0] dbg_pc_i,
  output logic [PC_W-1:0] next_pc_o
);
  localparam logic [PC_W-1:0] StepW = PC_W'(STEP);

  logic [PC_W-1:0] seq_pc;
  assign seq_pc = pc_i + StepW;

  always_comb begin
    unique case (kind_i)
      RT_NORMAL: next_pc_o = trap_pc_i;
      RT_DEBUG:  next_pc_o = dbg_pc_i;
      default:   next_pc_o = seq_pc;
    endcase
  end
endmodule

// File: rtl/rett_status.sv
module rett_status
  import rett_pkg::*;
(
  input  rt_kind_e kind_i,
  input  logic     sup_i,
  input  logic     prev_sup_i,
  input  logic     trap_en_i,
  input  logic     dbg_sup_i,
  input  logic     dbg_trap_en_i,
  output logic     sup_o,
  output logic     trap_en_o,
  output logic     dbg_clr_o,
  output logic     halt_o,
  output logic     illegal_o
);
  always_comb begin
    sup_o     = sup_i;
    trap_en_o = trap_en_i;
    dbg_clr_o = 1'b0;
    halt_o    = 1'b0;
    illegal_o = 1'b0;
    unique case (kind_i)
      RT_HALT:    halt_o = 1'b1;
      RT_ILLEGAL: illegal_o = 1'b1;
      RT_NORMAL: begin
        sup_o     = prev_sup_i;
        trap_en_o = 1'b1;
      end
      RT_DEBUG: begin
        sup_o     = dbg_sup_i;
        trap_en_o = dbg_trap_en_i;
        dbg_clr_o = 1'b1;
      end
      default: ;
    endcase
  end

  // R8
  always_comb begin
    req_onehot_chk: assert ($onehot0({halt_o, illegal_o, dbg_clr_o}));
  end
endmodule

// File: rtl/rett_ctl.sv
module rett_ctl
  import rett_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int STEP = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            sup_i,
  input  logic            prev_sup_i,
  input  logic            trap_en_i,
  input  logic            dbg_mode_i,
  input  logic            dbg_field_i,
  input  logic [PC_W-1:0] trap_pc_i,
  input  logic [PC_W-1:0] dbg_pc_i,
  input  logic            dbg_sup_i,
  input  logic            dbg_trap_en_i,
  output logic [PC_W-1:0] next_pc_o,
  output logic            sup_o,
  output logic            trap_en_o,
  output logic            dbg_clr_o,
  output logic            halt_o,
  output logic            illegal_o,
  output logic            done_o
);
  localparam logic [PC_W-1:0] StepW = PC_W'(STEP);

  rt_kind_e        kind;
  logic [PC_W-1:0] pc_n;
  logic            sup_n, et_n, clr_n, halt_n, ill_n;

  rett_classify u_classify (
    .sup_i       (sup_i),
    .trap_en_i   (trap_en_i),
    .dbg_mode_i  (dbg_mode_i),
    .dbg_field_i (dbg_field_i),
    .kind_o      (kind)
  );

  rett_target #(.PC_W(PC_W), .STEP(STEP)) u_target (
    .kind_i    (kind),
    .pc_i      (pc_i),
    .trap_pc_i (trap_pc_i),
    .dbg_pc_i  (dbg_pc_i),
    .next_pc_o (pc_n)
  );

  rett_status u_status (
    .kind_i        (kind),
    .sup_i         (sup_i),
    .prev_sup_i    (prev_sup_i),
    .trap_en_i     (trap_en_i),
    .dbg_sup_i     (dbg_sup_i),
    .dbg_trap_en_i (dbg_trap_en_i),
    .sup_o         (sup_n),
    .trap_en_o     (et_n),
    .dbg_clr_o     (clr_n),
    .halt_o        (halt_n),
    .illegal_o     (ill_n)
  );

  // result and status hold between returns
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      next_pc_o <= '0;
      sup_o     <= 1'b1;
      trap_en_o <= 1'b0;
    end else if (valid_i) begin
      next_pc_o <= pc_n;
      sup_o     <= sup_n;
      trap_en_o <= et_n;
    end
  end

  // pulses drop on any cycle without a return
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dbg_clr_o <= 1'b0;
      halt_o    <= 1'b0;
      illegal_o <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      dbg_clr_o <= valid_i & clr_n;
      halt_o    <= valid_i & halt_n;
      illegal_o <= valid_i & ill_n;
      done_o    <= valid_i;
    end
  end

  // R9
  pulse_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> !(halt_o || illegal_o || dbg_clr_o || done_o));

  // R9
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> ($stable(next_pc_o) && $stable(sup_o) && $stable(trap_en_o)));

  // R2
  halt_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && !sup_i && !trap_en_i) |->
      (halt_o && next_pc_o == $past(pc_i) + StepW));

  // R4
  illegal_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && sup_i && trap_en_i) |->
      (illegal_o && sup_o && trap_en_o && next_pc_o == $past(pc_i) + StepW));

  // R5
  normal_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && sup_i && !trap_en_i && !dbg_mode_i && !dbg_field_i) |->
      (next_pc_o == $past(trap_pc_i) && trap_en_o && sup_o == $past(prev_sup_i)));

  // R6
  debug_ret_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && sup_i && !trap_en_i && dbg_mode_i && dbg_field_i) |->
      (dbg_clr_o && next_pc_o == $past(dbg_pc_i) && sup_o == $past(dbg_sup_i)
       && trap_en_o == $past(dbg_trap_en_i)));
endmodule

// File: tb/rett_ctl_tb.sv
module rett_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;

  // stimulus {sup, prev_sup, trap_en, dbg_mode, dbg_field, dbg_trap_en, dbg_sup}
  // expected {sel[1:0] (0 = pc+4, 1 = trap_pc, 2 = dbg_pc), sup, trap_en, clr, halt, illegal}
  localparam logic [13:0] VEC [12] = '{
    14'b0100011_00_00010,  // R2 halt
    14'b0001111_00_00010,  // R8 halt despite debug return pattern
    14'b0110000_00_01000,  // R3 user
    14'b0011100_00_01000,  // R8 user despite debug return pattern
    14'b1010000_00_11001,  // R4 illegal
    14'b1111100_00_11001,  // R8 illegal beats debug return
    14'b1000011_01_01000,  // R5 normal, prev_sup 0
    14'b1100000_01_11000,  // R5 normal, prev_sup 1
    14'b1001110_10_01100,  // R6 debug, restores sup 0 / et 1
    14'b1101101_10_10100,  // R6 debug, restores sup 1 / et 0
    14'b1101011_00_10000,  // R7 debug mode, field 0
    14'b1000111_00_10000   // R7 normal mode, field 1
  };

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [PC_W-1:0] pc_i = '0, trap_pc_i = '0, dbg_pc_i = '0;
  logic            sup_i = 1'b0, prev_sup_i = 1'b0, trap_en_i = 1'b0;
  logic            dbg_mode_i = 1'b0, dbg_field_i = 1'b0;
  logic            dbg_sup_i = 1'b0, dbg_trap_en_i = 1'b0;
  logic [PC_W-1:0] next_pc_o;
  logic            sup_o, trap_en_o, dbg_clr_o, halt_o, illegal_o, done_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  rett_ctl #(.PC_W(PC_W), .STEP(4)) dut_i (
    .clk_i, .rst_ni, .valid_i, .pc_i, .sup_i, .prev_sup_i, .trap_en_i,
    .dbg_mode_i, .dbg_field_i, .trap_pc_i, .dbg_pc_i, .dbg_sup_i, .dbg_trap_en_i,
    .next_pc_o, .sup_o, .trap_en_o, .dbg_clr_o, .halt_o, .illegal_o, .done_o
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [6:0] st, input logic [PC_W-1:0] pc,
                       input logic [PC_W-1:0] tpc, input logic [PC_W-1:0] dpc);
    @(negedge clk_i);
    {sup_i, prev_sup_i, trap_en_i, dbg_mode_i, dbg_field_i, dbg_trap_en_i, dbg_sup_i} = st;
    pc_i = pc; trap_pc_i = tpc; dbg_pc_i = dpc;
    valid_i = 1'b1;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  function automatic string req_of(input logic [6:0] st, input logic [6:0] ex);
    if (ex[1]) return "R2";
    if (ex[0]) return "R4";
    if (ex[6:5] == 2'd1) return "R5";
    if (ex[6:5] == 2'd2) return "R6";
    if (!st[6]) return "R3";
    return "R7";
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset values
    check("R1", 64'(next_pc_o), 64'h0);
    check("R1", 64'({sup_o, trap_en_o}), 64'b10);
    check("R1", 64'({dbg_clr_o, halt_o, illegal_o, done_o}), 64'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", 64'({sup_o, trap_en_o, done_o}), 64'b100);

    for (int i = 0; i < 12; i++) begin
      logic [6:0] st, ex;
      logic [PC_W-1:0] pc, tpc, dpc, epc;
      string r;
      st = VEC[i][13:7];
      ex = VEC[i][6:0];
      pc  = 32'h0000_1000 + 32'(i * 16);
      tpc = 32'h8000_0000 + 32'(i * 256);
      dpc = 32'hC000_0000 + 32'(i * 256);
      epc = (ex[6:5] == 2'd1) ? tpc : (ex[6:5] == 2'd2) ? dpc : pc + 32'd4;
      r = req_of(st, ex);
      drive(st, pc, tpc, dpc);
      check(r, 64'(next_pc_o), 64'(epc));
      check(r, 64'({sup_o, trap_en_o}), 64'(ex[4:3]));
      check(r, 64'({dbg_clr_o, halt_o, illegal_o, done_o}), 64'({ex[2:0], 1'b1}));
    end

    // R9 idle cycle after a result: pulses drop, result holds
    @(negedge clk_i);
    check("R9", 64'({dbg_clr_o, halt_o, illegal_o, done_o}), 64'b0);
    check("R9", 64'(next_pc_o), 64'(32'h0000_1000 + 32'(11 * 16) + 32'd4));
    check("R9", 64'({sup_o, trap_en_o}), 64'b10);

    // R9 inputs changing without valid have no effect
    sup_i = 1'b1; trap_en_i = 1'b0; prev_sup_i = 1'b0; dbg_field_i = 1'b0; dbg_mode_i = 1'b0;
    trap_pc_i = 32'h1234_5678;
    @(negedge clk_i);
    check("R9", 64'(next_pc_o), 64'(32'h0000_1000 + 32'(11 * 16) + 32'd4));
    check("R9", 64'({sup_o, trap_en_o, done_o}), 64'b100);

    // R9 back-to-back returns: halt then debug return
    @(negedge clk_i);
    {sup_i, prev_sup_i, trap_en_i, dbg_mode_i, dbg_field_i, dbg_trap_en_i, dbg_sup_i} = 7'b0000000;
    pc_i = 32'h0000_2000;
    valid_i = 1'b1;
    @(negedge clk_i);
    check("R9", 64'({halt_o, done_o}), 64'b11);
    {sup_i, prev_sup_i, trap_en_i, dbg_mode_i, dbg_field_i, dbg_trap_en_i, dbg_sup_i} = 7'b1001111;
    dbg_pc_i = 32'hDEAD_BEE0;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R9", 64'({dbg_clr_o, halt_o, done_o}), 64'b101);
    check("R6", 64'(next_pc_o), 64'h0000_0000_DEAD_BEE0);
    check("R6", 64'({sup_o, trap_en_o}), 64'b11);

    // R10 PC wrap
    drive(7'b0010000, 32'hFFFF_FFFC, 32'h0, 32'h0);
    check("R10", 64'(next_pc_o), 64'h0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule